// File: doc/BRIEF.md
# Bus Clock Output Controller

This block derives the bus clock phase from the oscillator clock and decides whether that phase is driven onto an external clock pin. Out of reset the divider gives one low and one high oscillator cycle per bus cycle, which is half the oscillator rate. An access to slow external memory may ask for a longer high phase. The extra length is a count of 0 to 3 oscillator cycles. A stop request freezes the bus clock low.

A two-bit operating-mode code sets the behaviour of the pin. In single-chip user mode the pin starts off. In single-chip special mode and in the expanded modes it starts on. Software can override this default with a write. In peripheral test mode the block never drives the pin. It takes the pin as an input instead, and the sampled pin level becomes the bus clock.

Top module: `bus_clk_ctl`

## Requirements
- R1: While reset is held, bus_clk is 0. Once reset is released, pin_oe follows the default for the present mode. The mode codes are 00 for user, 01 for special, 10 for peripheral and 11 for expanded. Only the 01 and 11 codes give a pin_oe of 1.
- R2: With no stretch and no stop, outside peripheral mode, bus_clk toggles on every oscillator edge. A low phase always lasts exactly one oscillator cycle.
- R3: In mode 00 the pin is off after reset. A write with pin_en_wr=1 and pin_en_val=1 sets pin_oe to 1 from the next edge.
- R4: In mode 01 the pin is on after reset. A write with pin_en_val=0 clears pin_oe from the next edge.
- R5: In mode 10, pin_oe is 0 and bus_clk equals pin_in as sampled at the previous edge (with no synchronizer stages). An enable write in this mode leaves pin_oe at 0.
- R6: While stop_req is 1, bus_clk is 0 from the next edge and stays 0, with no internal toggling. At the first edge with stop_req at 0, bus_clk rises, and it then keeps a full high phase.
- R7: When stretch_req is 1 at the edge where bus_clk rises, the high phase lasts 1+stretch_cnt oscillator cycles. When stretch_req is 0 at that edge, the high phase lasts 1 cycle.
- R8: In mode 11 the pin is on after reset. A write with pin_en_val=0 turns it off.
- R9: pin_out equals bus_clk while pin_oe is 1, and is 0 while pin_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Operating-mode code |
| pin_en_wr | input | 1 | Software write strobe for the pin enable |
| pin_en_val | input | 1 | Value written to the pin enable |
| stop_req | input | 1 | Stop mode: hold all clocking |
| stretch_req | input | 1 | Slow access: lengthen the coming high phase |
| stretch_cnt | input | STRETCH_W | Extra high-phase oscillator cycles |
| pin_in | input | 1 | Pin level, used as the clock in peripheral mode |
| bus_clk | output | 1 | Bus clock phase |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Every result comes from a register, so the divider phase, the pin enable after a write, the stop hold and the sampled pin_in are all due one oscillator edge after the stimulus that causes them. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a period after the rising edge that updates them. The stretch vectors measure the high phase by counting consecutive falling-edge samples at 1. Each vector starts from a sample where bus_clk is 0, so the request is seen at the edge where bus_clk rises.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
   typedef enum logic [1:0] {
      MODE_USER     = 2'b00,
      MODE_SPECIAL  = 2'b01,
      MODE_PERIPH   = 2'b10,
      MODE_EXPANDED = 2'b11
   } bclk_mode_e;
endpackage

// File: rtl/bclk_pin_sync.sv
module bclk_pin_sync #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic pin_s
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad
         $error("SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin_in;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (SYNC_STAGES == 1) sh_q <= pin_in;
            else sh_q <= {sh_q[SYNC_STAGES-2:0], pin_in};
         end
         assign pin_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider #(
   parameter int STRETCH_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stop_req,
   input  logic                 periph,
   input  logic                 ext_clk,
   input  logic                 stretch_req,
   input  logic [STRETCH_W-1:0] stretch_cnt,
   output logic                 phase
);
   localparam int MAX_EXTRA = (1 << STRETCH_W) - 1;
   localparam logic [STRETCH_W-1:0] ONE = STRETCH_W'(1);

   generate
      if (STRETCH_W < 1 || STRETCH_W > 4) begin : g_bad
         $error("STRETCH_W must be 1..4");
      end
   endgenerate

   logic                 phase_q;
   logic [STRETCH_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         cnt_q   <= '0;
      end else if (stop_req) begin
         phase_q <= 1'b0;
         cnt_q   <= '0;
      end else if (periph) begin
         phase_q <= ext_clk;
         cnt_q   <= '0;
      end else if (!phase_q) begin
         phase_q <= 1'b1;
         cnt_q   <= stretch_req ? stretch_cnt : '0;
      end else if (cnt_q != '0) begin
         cnt_q   <= cnt_q - ONE;
      end else begin
         phase_q <= 1'b0;
      end
   end

   assign phase = phase_q;

   // Checker state: completed high cycles, saturating.
   logic [STRETCH_W+1:0] hi_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_q <= '0;
      else if (periph || !phase_q) hi_q <= '0;
      else if (hi_q != '1) hi_q <= hi_q + 1'b1;
   end

   // R6
   a_r6_stop_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !phase);
   // R2
   a_r2_low_single: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase && !stop_req && !periph) |=> phase);
   // R7
   a_r7_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (phase && !periph) |-> (hi_q <= (STRETCH_W+2)'(MAX_EXTRA)));
   // R5
   a_r5_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (periph && !stop_req) |=> (phase == $past(ext_clk)));
endmodule

// File: rtl/bclk_pin_ctl.sv
module bclk_pin_ctl
   import bclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       en_wr,
   input  logic       en_val,
   input  logic       bus_clk,
   output logic       periph,
   output logic       pin_out,
   output logic       pin_oe
);
   bclk_mode_e mode_e;
   logic       touched_q;
   logic       en_q;
   logic       dflt_en;
   logic       eff_en;

   assign mode_e  = bclk_mode_e'(mode);
   assign periph  = (mode_e == MODE_PERIPH);
   assign dflt_en = (mode_e != MODE_USER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         touched_q <= 1'b0;
         en_q      <= 1'b0;
      end else if (en_wr) begin
         touched_q <= 1'b1;
         en_q      <= en_val;
      end
   end

   assign eff_en  = touched_q ? en_q : dflt_en;
   assign pin_oe  = eff_en && !periph;
   assign pin_out = bus_clk && pin_oe;

   // R9
   a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_out);
   // R5
   a_r5_periph_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      periph |-> !pin_oe);
   // R3
   a_r3_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !periph) |=> (pin_oe == ($past(en_val) && !periph)));
endmodule

// File: rtl/bus_clk_ctl.sv
module bus_clk_ctl #(
   parameter int STRETCH_W   = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic                 osc_clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode,
   input  logic                 pin_en_wr,
   input  logic                 pin_en_val,
   input  logic                 stop_req,
   input  logic                 stretch_req,
   input  logic [STRETCH_W-1:0] stretch_cnt,
   input  logic                 pin_in,
   output logic                 bus_clk,
   output logic                 pin_out,
   output logic                 pin_oe
);
   logic pin_s;
   logic periph;

   bclk_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(osc_clk), .rst_n(rst_n), .pin_in(pin_in), .pin_s(pin_s)
   );

   bclk_divider #(.STRETCH_W(STRETCH_W)) u_div (
      .clk(osc_clk), .rst_n(rst_n), .stop_req(stop_req), .periph(periph),
      .ext_clk(pin_s), .stretch_req(stretch_req), .stretch_cnt(stretch_cnt),
      .phase(bus_clk)
   );

   bclk_pin_ctl u_pin (
      .clk(osc_clk), .rst_n(rst_n), .mode(mode), .en_wr(pin_en_wr),
      .en_val(pin_en_val), .bus_clk(bus_clk), .periph(periph),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // R1
   a_r1_reset_low: assert property (@(posedge osc_clk)
      !rst_n |-> !bus_clk);
endmodule

// File: tb/bus_clk_ctl_bench.sv
module bus_clk_ctl_bench;
   localparam int CLK_PERIOD = 10;
   // {stretch_req, stretch_cnt[1:0], expected high length[2:0]}
   localparam logic [5:0] VEC [0:4] = '{6'b0_11_001, 6'b1_00_001,
                                        6'b1_01_010, 6'b1_10_011, 6'b1_11_100};

   logic       osc_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       pin_en_wr = 1'b0, pin_en_val = 1'b0;
   logic       stop_req = 1'b0, stretch_req = 1'b0;
   logic [1:0] stretch_cnt = 2'b00;
   logic       pin_in = 1'b0;
   logic       bus_clk, pin_out, pin_oe;
   int         errors = 0, checks = 0;

   always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

   bus_clk_ctl u_bus_clk_ctl (
      .osc_clk(osc_clk), .rst_n(rst_n), .mode(mode), .pin_en_wr(pin_en_wr),
      .pin_en_val(pin_en_val), .stop_req(stop_req), .stretch_req(stretch_req),
      .stretch_cnt(stretch_cnt), .pin_in(pin_in), .bus_clk(bus_clk),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      @(negedge osc_clk);
      rst_n = 1'b0; mode = m; stop_req = 0; stretch_req = 0; pin_en_wr = 0;
      @(negedge osc_clk);
      check("R1 bus_clk in reset", bus_clk, 0);
      rst_n = 1'b1;
      @(negedge osc_clk);
   endtask

   task automatic write_en(input logic v);
      pin_en_wr = 1'b1; pin_en_val = v;
      @(negedge osc_clk);
      pin_en_wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int len;
      int prev;
      // R1 / R4: special mode, pin on by default
      do_reset(2'b01);
      check("R1 oe default mode01", pin_oe, 1);
      // R2 / R9: plain divide by two
      prev = bus_clk;
      for (int i = 0; i < 8; i++) begin
         @(negedge osc_clk);
         check("R2 toggle", bus_clk, prev ? 0 : 1);
         check("R9 pin_out mirrors", pin_out, bus_clk);
         prev = bus_clk;
      end
      // R7: stretch vectors
      for (int v = 0; v < 5; v++) begin
         @(negedge osc_clk);
         while (bus_clk) @(negedge osc_clk);
         stretch_req = VEC[v][5];
         stretch_cnt = VEC[v][4:3];
         len = 0;
         @(negedge osc_clk);
         while (bus_clk) begin
            len++;
            @(negedge osc_clk);
         end
         stretch_req = 1'b0;
         check("R7 high length", len, int'(VEC[v][2:0]));
         @(negedge osc_clk);
         check("R2 low is one cycle", bus_clk, 1);
      end
      // R6: stop
      stop_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge osc_clk);
         check("R6 held low in stop", bus_clk, 0);
         check("R9 pin_out low in stop", pin_out, 0);
      end
      stop_req = 1'b0;
      @(negedge osc_clk);
      check("R6 rises after stop", bus_clk, 1);
      @(negedge osc_clk);
      check("R6 full high then low", bus_clk, 0);
      // R4: software disable
      write_en(1'b0);
      check("R4 oe cleared", pin_oe, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge osc_clk);
         check("R9 pin_out 0 when off", pin_out, 0);
      end
      // R3: user mode
      do_reset(2'b00);
      check("R3 oe off after reset", pin_oe, 0);
      check("R9 pin_out off", pin_out, 0);
      write_en(1'b1);
      check("R3 oe set by write", pin_oe, 1);
      @(negedge osc_clk);
      check("R9 pin_out mirrors after enable", pin_out, bus_clk);
      // R8: expanded mode
      do_reset(2'b11);
      check("R8 oe on after reset", pin_oe, 1);
      write_en(1'b0);
      check("R8 oe off by write", pin_oe, 0);
      // R5: peripheral mode
      do_reset(2'b10);
      check("R1 oe default mode10", pin_oe, 0);
      pin_in = 1'b1;
      @(negedge osc_clk);
      check("R5 bus_clk follows pin high", bus_clk, 1);
      check("R5 oe off", pin_oe, 0);
      @(negedge osc_clk);
      check("R5 holds with pin high", bus_clk, 1);
      pin_in = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge osc_clk);
         check("R5 bus_clk follows pin low", bus_clk, 0);
      end
      write_en(1'b1);
      check("R5 write ignored", pin_oe, 0);
      check("R5 pin_out quiet", pin_out, 0);
      pin_in = 1'b1;
      stop_req = 1'b1;
      @(negedge osc_clk);
      check("R6 stop in peripheral mode", bus_clk, 0);
      stop_req = 1'b0;
      @(negedge osc_clk);
      check("R5 resumes following pin", bus_clk, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule